// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Port

This block is the slave side of a sigma-delta converter's serial interface, written so that it can be synthesized. A host reaches it over an SPI bus and can write and read a small set of internal registers. Each time the modulator finishes a conversion, it pulses `conv_done` and presents the result as a parallel word. The block latches that word, clears an active-low ready flag, and shows the flag on the single output pin, which carries both the ready indication and serial data.

There are two ways to read. In the default mode the host sends a one-byte command and then clocks out the register it addresses. In streaming mode every new result is placed on the output pin with no command, and the host supplies only clock pulses. A run of consecutive ones on the data input returns the serial logic to its idle command state. The port works with four wires, or with three wires when chip select is tied low.

All serial inputs are oversampled in the `clk` domain. SCLK idles high. DIN is taken on SCLK rising edges, and the output moves on SCLK falling edges.

Top module: `adc_serial_port`

## Requirements
- R1: After reset the ready flag is high (no unread result), the output pin is high while chip select is low, the status register reads 8'h80, and the mode register reads its reset value 16'h000A.
- R2: A `conv_done` pulse latches `conv_word`, pulls the ready flag low, drives the pin low while the port waits for a command, and makes status bit 7 read 0.
- R3: A command byte has the layout bit7 = 0, bit6 = read (1) or write (0), bits 5:3 = address, bit2 = stream request, bits 1:0 = 00. Byte 8'h58 reads the 24-bit data register (address 3) MSB first, and the MSB is on the pin before the first rising edge.
- R4: Once a data register read has completed, the pin returns high. A later read of the data register returns the same word again.
- R5: Command 8'h08 followed by 16 bits writes the mode register (address 1). Command 8'h48 reads those bits back.
- R6: Byte 8'h5C enters streaming mode. Each new result then pulls the pin low and is shifted out with no command. After its 24 bits the pin stays high until the next result, so extra clocks return ones.
- R7: In streaming mode, a new result that arrives during a transfer restarts the transfer with the new word, and the old word is lost.
- R8: In streaming mode the byte 8'h58 sent on DIN ends the mode. After that, other registers can be reached by command.
- R9: Thirty-two consecutive ones sampled on DIN return the port to the command state and clear streaming mode. The mode register keeps its contents.
- R10: While `cs_n` is high, `dout_oe` is low and SCLK edges are ignored.
- R11: If a result arrives in the same cycle as the last rising edge of a data register read, the read still returns the old word, the ready flag stays low, and the new word is latched.
- R12: A command byte with bit7 = 1 or bits 1:0 not 00 is ignored, and the byte after it is decoded as a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idles high |
| cs_n | input | 1 | Active-low chip select (held low for 3-wire use) |
| din | input | 1 | Serial data from host |
| conv_done | input | 1 | One-cycle strobe: a conversion finished |
| conv_word | input | DW | Conversion result |
| dout | output | 1 | Combined serial data and active-low ready |
| dout_oe | output | 1 | Output enable for the pin, low while deselected |

## Verification
Two events can fall in the same `clk` cycle. One is a new conversion completing, which clears the ready flag and reloads the data register. The other is the final rising SCLK edge of a data read, which sets the flag. The bench times the `conv_done` pulse to land exactly on the cycle in which the synchronized rising edge takes effect. It then checks three things: the finished read carries the old word, the pin stays low, and a following read returns the new word. In streaming mode it also sends a conversion in the middle of a transfer and checks that the restarted transfer delivers only the newer word.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;

  typedef enum logic [2:0] {
    ST_CMD     = 3'd0,
    ST_WR      = 3'd1,
    ST_RD      = 3'd2,
    ST_CR_WAIT = 3'd3,
    ST_CR_ARM  = 3'd4,
    ST_CR_SEND = 3'd5
  } port_state_e;

  localparam logic [2:0] ADDR_STATUS = 3'd0;
  localparam logic [2:0] ADDR_MODE   = 3'd1;
  localparam logic [2:0] ADDR_DATA   = 3'd3;

  localparam logic [7:0] CMD_EXIT    = 8'h58;

endpackage

// File: rtl/adc_sp_sync.sv
module adc_sp_sync #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic din,
  output logic rise,
  output logic fall,
  output logic din_s,
  output logic cs_act
);

  logic [SYNC-1:0] sclk_q;
  logic [SYNC-1:0] cs_q;
  logic [SYNC-1:0] din_q;
  logic            sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= '1;
      cs_q      <= '1;
      din_q     <= '0;
      sclk_prev <= 1'b1;
    end else begin
      sclk_q    <= {sclk_q[SYNC-2:0], sclk};
      cs_q      <= {cs_q[SYNC-2:0], cs_n};
      din_q     <= {din_q[SYNC-2:0], din};
      sclk_prev <= sclk_q[SYNC-1];
    end
  end

  assign cs_act = ~cs_q[SYNC-1];
  assign din_s  = din_q[SYNC-1];
  assign rise   = cs_act &  sclk_q[SYNC-1] & ~sclk_prev;
  assign fall   = cs_act & ~sclk_q[SYNC-1] &  sclk_prev;

endmodule

// File: rtl/adc_sp_ones.sv
module adc_sp_ones #(
  parameter int RUN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic din_s,
  output logic srst
);

  localparam int CNTW = $clog2(RUN + 1);

  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            at_end;

  assign at_end = (cnt_q == CNTW'(RUN - 1));
  assign srst   = rise & din_s & at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (rise) begin
      if (!din_s || at_end) cnt_d = '0;
      else                  cnt_d = cnt_q + CNTW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/adc_sp_regs.sv
module adc_sp_regs #(
  parameter int          DW       = 24,
  parameter int          MW       = 16,
  parameter logic [MW-1:0] MODE_RST = MW'(16'h000A)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_done,
  input  logic [DW-1:0] conv_word,
  input  logic          rd_done,
  input  logic          mode_we,
  input  logic [MW-1:0] mode_wdata,
  output logic          rdy_n,
  output logic [DW-1:0] data_q,
  output logic [MW-1:0] mode_q
);

  logic rdy_n_d;

  always_comb begin
    rdy_n_d = rdy_n;
    if (conv_done)    rdy_n_d = 1'b0;
    else if (rd_done) rdy_n_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_n  <= 1'b1;
      data_q <= '0;
      mode_q <= MODE_RST;
    end else begin
      rdy_n <= rdy_n_d;
      if (conv_done) data_q <= conv_word;
      if (mode_we)   mode_q <= mode_wdata;
    end
  end

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_sp_pkg::*;
#(
  parameter int            DW       = 24,
  parameter int            MW       = 16,
  parameter int            ONES_RUN = 32,
  parameter int            SYNC     = 2,
  parameter logic [MW-1:0] MODE_RST = MW'(16'h000A)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk,
  input  logic          cs_n,
  input  logic          din,
  input  logic          conv_done,
  input  logic [DW-1:0] conv_word,
  output logic          dout,
  output logic          dout_oe
);

  localparam int SHW = (DW > MW) ? DW : MW;
  localparam int CW  = $clog2(SHW + 1);

  logic rst_meta, rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_n_s, rst_meta} <= 2'b00;
    else        {rst_n_s, rst_meta} <= {rst_meta, 1'b1};
  end

  logic rise, fall, din_s, cs_act, srst;
  logic rd_done, mode_we, rdy_n;
  logic [MW-1:0] mode_wdata, mode_q;
  logic [DW-1:0] data_q;

  adc_sp_sync #(.SYNC(SYNC)) sync_i (
    .clk(clk), .rst_n(rst_n_s), .sclk(sclk), .cs_n(cs_n), .din(din),
    .rise(rise), .fall(fall), .din_s(din_s), .cs_act(cs_act)
  );

  adc_sp_ones #(.RUN(ONES_RUN)) ones_i (
    .clk(clk), .rst_n(rst_n_s), .rise(rise), .din_s(din_s), .srst(srst)
  );

  adc_sp_regs #(.DW(DW), .MW(MW), .MODE_RST(MODE_RST)) regs_i (
    .clk(clk), .rst_n(rst_n_s), .conv_done(conv_done), .conv_word(conv_word),
    .rd_done(rd_done), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .rdy_n(rdy_n), .data_q(data_q), .mode_q(mode_q)
  );

  port_state_e      state_q, state_d;
  logic [CW-1:0]    bitcnt_q, bitcnt_d;
  logic [CW-1:0]    len_q, len_d;
  logic [2:0]       addr_q, addr_d;
  logic [MW-2:0]    in_q, in_d;
  logic [SHW-1:0]   out_q, out_d;
  logic             cread_q, cread_d;
  logic [6:0]       mon_q, mon_d;
  logic [2:0]       mcnt_q, mcnt_d;
  logic [7:0]       cmd_byte, mon_byte;

  function automatic logic [SHW-1:0] rd_word(input logic [2:0] a);
    case (a)
      ADDR_STATUS: rd_word = SHW'({rdy_n, 7'd0}) << (SHW - 8);
      ADDR_MODE:   rd_word = SHW'(mode_q) << (SHW - MW);
      ADDR_DATA:   rd_word = SHW'(data_q) << (SHW - DW);
      default:     rd_word = '0;
    endcase
  endfunction

  function automatic logic [CW-1:0] rd_len(input logic [2:0] a);
    case (a)
      ADDR_MODE: rd_len = CW'(MW);
      ADDR_DATA: rd_len = CW'(DW);
      default:   rd_len = CW'(8);
    endcase
  endfunction

  assign cmd_byte   = {in_q[6:0], din_s};
  assign mon_byte   = {mon_q, din_s};
  assign mode_wdata = {in_q, din_s};

  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    len_d    = len_q;
    addr_d   = addr_q;
    in_d     = in_q;
    out_d    = out_q;
    cread_d  = cread_q;
    mon_d    = mon_q;
    mcnt_d   = mcnt_q;
    rd_done  = 1'b0;
    mode_we  = 1'b0;

    unique case (state_q)
      ST_CMD: begin
        if (rise) begin
          in_d     = {in_q[MW-3:0], din_s};
          bitcnt_d = bitcnt_q + CW'(1);
          if (bitcnt_q == CW'(7)) begin
            bitcnt_d = '0;
            if (!cmd_byte[7] && cmd_byte[1:0] == 2'b00) begin
              addr_d = cmd_byte[5:3];
              if (cmd_byte[6]) begin
                if (cmd_byte[5:3] == ADDR_DATA && cmd_byte[2]) begin
                  cread_d = 1'b1;
                  mcnt_d  = '0;
                  state_d = ST_CR_WAIT;
                end else begin
                  out_d   = rd_word(cmd_byte[5:3]);
                  len_d   = rd_len(cmd_byte[5:3]);
                  state_d = ST_RD;
                end
              end else begin
                len_d   = (cmd_byte[5:3] == ADDR_MODE) ? CW'(MW) : CW'(8);
                state_d = ST_WR;
              end
            end
          end
        end
      end
      ST_WR: begin
        if (rise) begin
          in_d     = {in_q[MW-3:0], din_s};
          bitcnt_d = bitcnt_q + CW'(1);
          if (bitcnt_q == len_q - CW'(1)) begin
            bitcnt_d = '0;
            state_d  = ST_CMD;
            mode_we  = (addr_q == ADDR_MODE);
          end
        end
      end
      ST_RD: begin
        if (rise) begin
          bitcnt_d = bitcnt_q + CW'(1);
          if (bitcnt_q == len_q - CW'(1)) begin
            bitcnt_d = '0;
            state_d  = ST_CMD;
            rd_done  = (addr_q == ADDR_DATA);
          end
        end else if (fall && bitcnt_q != '0) begin
          out_d = out_q << 1;
        end
      end
      ST_CR_ARM: begin
        if (fall) state_d = ST_CR_SEND;
      end
      ST_CR_SEND: begin
        if (rise) begin
          bitcnt_d = bitcnt_q + CW'(1);
          if (bitcnt_q == CW'(DW - 1)) begin
            bitcnt_d = '0;
            rd_done  = 1'b1;
            state_d  = ST_CR_WAIT;
          end
        end else if (fall && bitcnt_q != '0) begin
          out_d = out_q << 1;
        end
      end
      default: ;
    endcase

    if (conv_done && cread_q) begin
      state_d  = ST_CR_ARM;
      out_d    = SHW'(conv_word) << (SHW - DW);
      bitcnt_d = '0;
      mcnt_d   = '0;
    end

    if (cread_q && rise) begin
      mon_d  = mon_byte[6:0];
      mcnt_d = mcnt_q + 3'd1;
      if (mcnt_q == 3'd7 && mon_byte == CMD_EXIT) begin
        cread_d  = 1'b0;
        state_d  = ST_CMD;
        bitcnt_d = '0;
      end
    end

    if (srst) begin
      state_d  = ST_CMD;
      cread_d  = 1'b0;
      bitcnt_d = '0;
      mcnt_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q  <= ST_CMD;
      bitcnt_q <= '0;
      len_q    <= '0;
      addr_q   <= '0;
      in_q     <= '0;
      out_q    <= '0;
      cread_q  <= 1'b0;
      mon_q    <= '0;
      mcnt_q   <= '0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      len_q    <= len_d;
      addr_q   <= addr_d;
      in_q     <= in_d;
      out_q    <= out_d;
      cread_q  <= cread_d;
      mon_q    <= mon_d;
      mcnt_q   <= mcnt_d;
    end
  end

  logic shifting;
  assign shifting = (state_q == ST_RD) || (state_q == ST_CR_SEND);
  assign dout     = cs_n ? 1'b1 : (shifting ? out_q[SHW-1] : rdy_n);
  assign dout_oe  = ~cs_n;

endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk
  import adc_sp_pkg::*;
#(
  parameter int DW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          conv_done,
  input logic [DW-1:0] conv_word,
  input logic          rdy_n,
  input logic [DW-1:0] data_q,
  input logic          cread_q,
  input port_state_e   state_q,
  input logic          srst,
  input logic          rd_done
);

  AST_CONV_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !rdy_n); // R2

  AST_CONV_LATCHES_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> data_q == $past(conv_word)); // R11

  AST_READ_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done && !conv_done |=> rdy_n); // R4

  AST_STREAM_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done && cread_q && !srst |=> (state_q == ST_CR_ARM || state_q == ST_CMD)); // R7

  AST_ONES_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (state_q == ST_CMD && !cread_q)); // R9

  AST_CMD_STATES_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !cread_q |-> (state_q == ST_CMD || state_q == ST_WR || state_q == ST_RD)); // R8

endmodule

bind adc_serial_port adc_serial_port_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n_s), .conv_done(conv_done), .conv_word(conv_word),
  .rdy_n(rdy_n), .data_q(data_q), .cread_q(cread_q), .state_q(state_q),
  .srst(srst), .rd_done(rd_done)
);

// File: tb/adc_serial_port_tb_top.sv
module adc_serial_port_tb_top;

  logic        clk, rst_n, sclk, cs_n, din, conv_done;
  logic [23:0] conv_word;
  logic        dout, dout_oe;
  int          n_checks = 0;
  int          n_fail   = 0;
  logic [31:0] r;

  localparam logic [23:0] CONV_VEC [0:5] = '{24'hA5C3F0, 24'h000001, 24'h800000,
                                             24'hFFFFFE, 24'h3C5A96, 24'h7FFFFF};

  adc_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
    .conv_done(conv_done), .conv_word(conv_word), .dout(dout), .dout_oe(dout_oe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic spi_bit(input logic b, output logic o);
    @(negedge clk);
    sclk = 1'b0;
    din  = b;
    repeat (4) @(negedge clk);
    o    = dout;
    sclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic xfer(input logic [31:0] w, input int n, output logic [31:0] rd);
    logic o;
    rd = '0;
    for (int i = n - 1; i >= 0; i--) begin
      spi_bit(w[i], o);
      rd = {rd[30:0], o};
    end
  endtask

  task automatic rd_reg(input logic [7:0] cmd, input int n, output logic [31:0] rd);
    logic [31:0] junk;
    xfer({24'd0, cmd}, 8, junk);
    xfer(32'd0, n, rd);
  endtask

  task automatic conv_pulse(input logic [23:0] w);
    @(negedge clk);
    conv_word = w;
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] junk;
    logic        o;
    rst_n = 1'b0; sclk = 1'b1; cs_n = 1'b1; din = 1'b0;
    conv_done = 1'b0; conv_word = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R10 / R1: deselected, then selected after reset
    check("R10 oe while deselected", {31'd0, dout_oe}, 32'd0);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 oe selected", {31'd0, dout_oe}, 32'd1);
    check("R1 pin high after reset", {31'd0, dout}, 32'd1);
    rd_reg(8'h40, 8, r);
    check("R1 status reset", r, 32'h80);
    rd_reg(8'h48, 16, r);
    check("R1 mode reset", r, 32'h000A);

    // R5: mode register write/read
    xfer(32'h08, 8, junk); xfer(32'hC3A5, 16, junk);
    rd_reg(8'h48, 16, r);
    check("R5 mode C3A5", r, 32'hC3A5);
    xfer(32'h08, 8, junk); xfer(32'h5A0F, 16, junk);
    rd_reg(8'h48, 16, r);
    check("R5 mode 5A0F", r, 32'h5A0F);

    // R2 R3 R4: table of conversion words
    for (int i = 0; i < 6; i++) begin
      conv_pulse(CONV_VEC[i]);
      check("R2 pin low on new result", {31'd0, dout}, 32'd0);
      rd_reg(8'h40, 8, r);
      check("R2 status ready bit low", r, 32'h00);
      rd_reg(8'h58, 24, r);
      check("R3 data read", r, {8'd0, CONV_VEC[i]});
      check("R4 pin high after read", {31'd0, dout}, 32'd1);
      rd_reg(8'h58, 24, r);
      check("R4 reread same word", r, {8'd0, CONV_VEC[i]});
    end

    // R12: invalid command bytes are skipped
    xfer(32'hFF, 8, junk);
    xfer(32'h4B, 8, junk);
    rd_reg(8'h48, 16, r);
    check("R12 decode after invalid bytes", r, 32'h5A0F);

    // R11: conversion on the final rising edge of a data read
    conv_pulse(24'h13579B);
    xfer(32'h58, 8, junk);
    xfer(32'd0, 23, r);
    @(negedge clk);
    sclk = 1'b0; din = 1'b0;
    repeat (4) @(negedge clk);
    o = dout;
    sclk = 1'b1;
    @(negedge clk);
    @(negedge clk);
    conv_word = 24'h2468AC;
    conv_done = 1'b1;
    @(negedge clk);
    conv_done = 1'b0;
    repeat (3) @(negedge clk);
    r = {r[30:0], o};
    check("R11 finished read has old word", r, 32'h0013579B);
    check("R11 ready stays low", {31'd0, dout}, 32'd0);
    rd_reg(8'h58, 24, r);
    check("R11 new word latched", r, 32'h002468AC);

    // R10: edges while deselected are ignored
    cs_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 oe low", {31'd0, dout_oe}, 32'd0);
    xfer(32'h48, 8, junk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    rd_reg(8'h48, 16, r);
    check("R10 framing kept", r, 32'h5A0F);

    // R6: streaming mode
    xfer(32'h5C, 8, junk);
    conv_pulse(24'hC0FFEE);
    check("R6 pin low on result", {31'd0, dout}, 32'd0);
    xfer(32'd0, 24, r);
    check("R6 streamed word", r, 32'h00C0FFEE);
    check("R6 pin high after read", {31'd0, dout}, 32'd1);
    xfer(32'd0, 8, r);
    check("R6 read only once", r, 32'hFF);

    // R7: new result during a transfer
    conv_pulse(24'h111111);
    xfer(32'd0, 8, junk);
    conv_pulse(24'h9ABCDE);
    check("R7 pin low on restart", {31'd0, dout}, 32'd0);
    xfer(32'd0, 24, r);
    check("R7 newer word only", r, 32'h009ABCDE);

    // R8: exit byte, then register access
    xfer(32'h58, 8, junk);
    rd_reg(8'h48, 16, r);
    check("R8 mode after exit", r, 32'h5A0F);
    conv_pulse(24'h0F0F0F);
    rd_reg(8'h40, 8, r);
    check("R8 status reachable", r, 32'h00);
    rd_reg(8'h58, 24, r);
    check("R8 data by command", r, 32'h000F0F0F);

    // R9: thirty-two ones in streaming mode
    xfer(32'h5C, 8, junk);
    conv_pulse(24'h654321);
    xfer(32'hFFFFFFFF, 32, junk);
    rd_reg(8'h48, 16, r);
    check("R9 mode kept, command state", r, 32'h5A0F);
    conv_pulse(24'h123456);
    rd_reg(8'h40, 8, r);
    check("R9 streaming cleared", r, 32'h00);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule